// File: doc/BRIEF.md
# Halt-Triggered Power Mode Controller

This block picks the low-power state that a small processor core enters when it executes its halt instruction. At the halt strobe it samples the idle-enable bit, the watchdog enable, the low-voltage-detector enable, the keep-system-oscillator-in-idle bit and the watchdog clock-source select. From these it chooses one of four low-power modes, or stays in run mode.

It drives registered clock-enable outputs for the system clock, the time base clock and the watchdog clock. When a low-power mode is entered, it pulses a watchdog clear for one cycle, sets the power-down flag and clears the time-out flag. A wake-up event brings the block back to run mode on the next edge and turns every clock back on.

The oscillators, the watchdog counter and the processor pipeline stay outside the block. The watchdog time-out event and the software clear of the power-down flag arrive as inputs.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: On the first clock edge with `rst` high, the block goes to run mode: `mode_o`=0, all three clock enables 1, `pdf_o`=0, `to_o`=0 and `wdt_clr_o`=0.
- R2: A halt in run mode with idle enable 0 and both the watchdog and detector enables 0 enters SLEEP0 (`mode_o`=1). The system, time base and watchdog clock enables are all 0.
- R3: A halt in run mode with idle enable 0 and the watchdog or detector enable set enters SLEEP1 (`mode_o`=2). The system and time base enables are 0, and the watchdog enable equals the clock-source select (1 = sub-oscillator).
- R4: A halt in run mode with idle enable 1 and the keep-oscillator bit 0 enters IDLE0 (`mode_o`=3). The system enable is 0, the time base enable is 1, and the watchdog enable equals the clock-source select.
- R5: A halt in run mode with idle enable 1 and the keep-oscillator bit 1 enters IDLE1 (`mode_o`=4) with all three enables at 1.
- R6: Every low-power entry takes effect at the edge that samples the halt. From that edge `wdt_clr_o` is 1 for exactly one cycle, `pdf_o` is 1 and `to_o` is 0.
- R7: The configuration inputs are captured at the halt. Changing them while in a low-power mode leaves `mode_o` and the clock enables unchanged.
- R8: A halt strobe while already in a low-power mode is ignored: no watchdog clear and no change of mode.
- R9: A wake-up while in a low-power mode returns to run mode at the next edge with all enables at 1, and `pdf_o` stays 1. A wake-up in run mode has no effect, and a halt together with a wake-up in run mode enters the low-power mode.
- R10: `pdf_clr_i` clears `pdf_o` at the next edge unless a low-power entry happens at that same edge. In that case the flag is set.
- R11: `wdt_timeout_i` sets `to_o` at the next edge unless a low-power entry happens at that same edge. In that case the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Halt instruction strobe |
| idle_en_i | input | 1 | Idle enable configuration bit |
| wdt_en_i | input | 1 | Watchdog enable |
| lvd_en_i | input | 1 | Low-voltage detector enable |
| sysosc_idle_i | input | 1 | Keep system oscillator running in idle |
| wdt_src_sub_i | input | 1 | Watchdog clock source: 1 = sub-oscillator, 0 = system clock |
| wake_i | input | 1 | Wake-up event |
| pdf_clr_i | input | 1 | Software clear of the power-down flag |
| wdt_timeout_i | input | 1 | Watchdog time-out event |
| mode_o | output | 3 | Current mode: 0 run, 1 SLEEP0, 2 SLEEP1, 3 IDLE0, 4 IDLE1 |
| sys_clk_en_o | output | 1 | System clock enable |
| tb_clk_en_o | output | 1 | Time base clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear pulse |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |

## Verification
Low-power entry can fall in the same cycle as a flag update. A halt can coincide with a software clear of the power-down flag, or with a watchdog time-out. The bench raises both strobes on one edge and expects the entry to win: the power-down flag is set and the time-out flag is cleared. A third case pairs halt with wake-up: in run mode the halt must win, and while asleep a halt on the wake-up edge must change nothing beyond the return to run mode.

// File: rtl/pwr_halt_pkg.sv
package pwr_halt_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_RUN    = 3'd0,
    PM_SLEEP0 = 3'd1,
    PM_SLEEP1 = 3'd2,
    PM_IDLE0  = 3'd3,
    PM_IDLE1  = 3'd4
  } pmode_e;

  typedef struct packed {
    logic idle_en;
    logic wdt_en;
    logic lvd_en;
    logic sysosc_on;
    logic wdt_src_sub;
  } halt_cfg_t;

  typedef struct packed {
    logic sys;
    logic tbase;
    logic wdt;
  } clk_en_t;

  localparam clk_en_t CLK_ALL_ON = '{sys: 1'b1, tbase: 1'b1, wdt: 1'b1};

endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_halt_pkg::*;
(
  input  halt_cfg_t cfg,
  output pmode_e    mode
);

  logic low_speed_busy;

  assign low_speed_busy = cfg.wdt_en | cfg.lvd_en;

  always_comb begin
    if (cfg.idle_en) begin
      mode = cfg.sysosc_on ? PM_IDLE1 : PM_IDLE0;
    end else begin
      mode = low_speed_busy ? PM_SLEEP1 : PM_SLEEP0;
    end
  end

endmodule

// File: rtl/pwr_clk_map.sv
module pwr_clk_map
  import pwr_halt_pkg::*;
(
  input  pmode_e  mode,
  input  logic    wdt_src_sub,
  output clk_en_t en
);

  always_comb begin
    en = CLK_ALL_ON;
    unique case (mode)
      PM_SLEEP0: begin
        en.sys   = 1'b0;
        en.tbase = 1'b0;
        en.wdt   = 1'b0;
      end
      PM_SLEEP1: begin
        en.sys   = 1'b0;
        en.tbase = 1'b0;
        en.wdt   = wdt_src_sub;
      end
      PM_IDLE0: begin
        en.sys   = 1'b0;
        en.tbase = 1'b1;
        en.wdt   = wdt_src_sub;
      end
      PM_IDLE1: en = CLK_ALL_ON;
      default:  en = CLK_ALL_ON;
    endcase
  end

endmodule

// File: rtl/pwr_status_flags.sv
module pwr_status_flags (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic pdf_clr,
  input  logic timeout,
  output logic pdf,
  output logic to
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pdf <= 1'b0;
      to  <= 1'b0;
    end else begin
      if (enter)        pdf <= 1'b1;
      else if (pdf_clr) pdf <= 1'b0;

      if (enter)        to <= 1'b0;
      else if (timeout) to <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_halt_ctrl.sv
module pwr_halt_ctrl
  import pwr_halt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                halt_i,
  input  logic                idle_en_i,
  input  logic                wdt_en_i,
  input  logic                lvd_en_i,
  input  logic                sysosc_idle_i,
  input  logic                wdt_src_sub_i,
  input  logic                wake_i,
  input  logic                pdf_clr_i,
  input  logic                wdt_timeout_i,
  output logic [MODE_W-1:0]   mode_o,
  output logic                sys_clk_en_o,
  output logic                tb_clk_en_o,
  output logic                wdt_clk_en_o,
  output logic                wdt_clr_o,
  output logic                pdf_o,
  output logic                to_o
);

  halt_cfg_t cfg_in;
  pmode_e    mode_q, dec_mode, mode_n;
  clk_en_t   en_q, en_n;
  logic      clr_q;
  logic      enter, leave;

  assign cfg_in = '{idle_en:     idle_en_i,
                    wdt_en:      wdt_en_i,
                    lvd_en:      lvd_en_i,
                    sysosc_on:   sysosc_idle_i,
                    wdt_src_sub: wdt_src_sub_i};

  assign enter  = halt_i && (mode_q == PM_RUN);
  assign leave  = wake_i && (mode_q != PM_RUN);
  assign mode_n = enter ? dec_mode : PM_RUN;

  pwr_mode_decode u_decode (
    .cfg  (cfg_in),
    .mode (dec_mode)
  );

  pwr_clk_map u_map (
    .mode        (mode_n),
    .wdt_src_sub (cfg_in.wdt_src_sub),
    .en          (en_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_RUN;
      en_q   <= CLK_ALL_ON;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= enter;
      if (enter || leave) begin
        mode_q <= mode_n;
        en_q   <= en_n;
      end
    end
  end

  pwr_status_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .enter   (enter),
    .pdf_clr (pdf_clr_i),
    .timeout (wdt_timeout_i),
    .pdf     (pdf_o),
    .to      (to_o)
  );

  assign mode_o       = mode_q;
  assign sys_clk_en_o = en_q.sys;
  assign tb_clk_en_o  = en_q.tbase;
  assign wdt_clk_en_o = en_q.wdt;
  assign wdt_clr_o    = clr_q;

endmodule

// File: rtl/pwr_halt_ctrl_chk.sv
module pwr_halt_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       halt_i,
  input logic       wake_i,
  input logic [2:0] mode_o,
  input logic       sys_clk_en_o,
  input logic       tb_clk_en_o,
  input logic       wdt_clk_en_o,
  input logic       wdt_clr_o,
  input logic       pdf_o,
  input logic       to_o
);

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (mode_o == 3'd0 && sys_clk_en_o && tb_clk_en_o && wdt_clk_en_o
                    && !pdf_o && !to_o && !wdt_clr_o)); // R1

  AST_SLEEP0_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1) |-> (!sys_clk_en_o && !tb_clk_en_o && !wdt_clk_en_o)); // R2

  AST_SLEEP1_TB_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |-> (!sys_clk_en_o && !tb_clk_en_o)); // R3

  AST_IDLE0_TB_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3) |-> (!sys_clk_en_o && tb_clk_en_o)); // R4

  AST_IDLE1_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> (sys_clk_en_o && tb_clk_en_o && wdt_clk_en_o)); // R5

  AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (halt_i && mode_o == 3'd0) |=> (pdf_o && !to_o && wdt_clr_o && mode_o != 3'd0)); // R6

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wdt_clr_o |=> !wdt_clr_o); // R6

  AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 3'd0 && !wake_i) |=> ($stable(mode_o) && $stable(sys_clk_en_o)
                                     && $stable(tb_clk_en_o) && $stable(wdt_clk_en_o)
                                     && !wdt_clr_o)); // R7

  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (rst)
    (wake_i && mode_o != 3'd0) |=> (mode_o == 3'd0 && sys_clk_en_o && tb_clk_en_o
                                    && wdt_clk_en_o && pdf_o)); // R9

endmodule

bind pwr_halt_ctrl pwr_halt_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .halt_i       (halt_i),
  .wake_i       (wake_i),
  .mode_o       (mode_o),
  .sys_clk_en_o (sys_clk_en_o),
  .tb_clk_en_o  (tb_clk_en_o),
  .wdt_clk_en_o (wdt_clk_en_o),
  .wdt_clr_o    (wdt_clr_o),
  .pdf_o        (pdf_o),
  .to_o         (to_o)
);

// File: tb/pwr_halt_ctrl_bench.sv
module pwr_halt_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_i = 1'b0, idle_en_i = 1'b0, wdt_en_i = 1'b0, lvd_en_i = 1'b0;
  logic       sysosc_idle_i = 1'b0, wdt_src_sub_i = 1'b0, wake_i = 1'b0;
  logic       pdf_clr_i = 1'b0, wdt_timeout_i = 1'b0;
  logic [2:0] mode_o;
  logic       sys_clk_en_o, tb_clk_en_o, wdt_clk_en_o, wdt_clr_o, pdf_o, to_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_halt_ctrl u_pwr_halt_ctrl (.*);

  // {idle, wdt, lvd, sysosc, src} , expected mode , {sys, tbase, wdt}
  localparam logic [10:0] VEC [9] = '{
    {5'b00001, 3'd1, 3'b000},
    {5'b00010, 3'd1, 3'b000},
    {5'b01001, 3'd2, 3'b001},
    {5'b00100, 3'd2, 3'b000},
    {5'b01111, 3'd2, 3'b001},
    {5'b10001, 3'd3, 3'b011},
    {5'b11000, 3'd3, 3'b010},
    {5'b10010, 3'd4, 3'b111},
    {5'b11111, 3'd4, 3'b111}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ens();
    return {sys_clk_en_o, tb_clk_en_o, wdt_clk_en_o};
  endfunction

  task automatic set_cfg(input logic [4:0] c);
    {idle_en_i, wdt_en_i, lvd_en_i, sysosc_idle_i, wdt_src_sub_i} = c;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1", "mode", 8'(mode_o), 8'd0);
    check("R1", "enables", 8'(ens()), 8'h7);
    check("R1", "flags", 8'({pdf_o, to_o, wdt_clr_o}), 8'd0);
    rst = 1'b0;
    tick();

    for (int i = 0; i < 9; i++) begin
      logic [4:0] c;
      logic [2:0] em, ee;
      string rq;
      {c, em, ee} = VEC[i];
      rq = (em == 3'd1) ? "R2" : (em == 3'd2) ? "R3" : (em == 3'd3) ? "R4" : "R5";
      // R11 time-out sets flag
      wdt_timeout_i = 1'b1; tick(); wdt_timeout_i = 1'b0;
      check("R11", "to set", 8'(to_o), 8'd1);
      // entry
      set_cfg(c); halt_i = 1'b1; tick(); halt_i = 1'b0;
      check(rq, "mode", 8'(mode_o), 8'(em));
      check(rq, "enables", 8'(ens()), 8'(ee));
      check("R6", "entry flags", 8'({pdf_o, to_o, wdt_clr_o}), 8'b101);
      // R7 config change while asleep
      set_cfg(~c); tick();
      check("R6", "clr single", 8'(wdt_clr_o), 8'd0);
      check("R7", "mode held", 8'(mode_o), 8'(em));
      check("R7", "enables held", 8'(ens()), 8'(ee));
      // R8 halt while asleep ignored
      halt_i = 1'b1; tick(); halt_i = 1'b0;
      check("R8", "mode", 8'(mode_o), 8'(em));
      check("R8", "no clr", 8'(wdt_clr_o), 8'd0);
      // R9 wake
      wake_i = 1'b1; tick(); wake_i = 1'b0;
      check("R9", "mode run", 8'(mode_o), 8'd0);
      check("R9", "enables on", 8'(ens()), 8'h7);
      check("R9", "pdf kept", 8'(pdf_o), 8'd1);
      // R10 software clear
      pdf_clr_i = 1'b1; tick(); pdf_clr_i = 1'b0;
      check("R10", "pdf cleared", 8'(pdf_o), 8'd0);
    end

    // R9 wake in run mode has no effect
    wake_i = 1'b1; tick(); wake_i = 1'b0;
    check("R9", "wake in run", 8'({mode_o, ens()}), 8'({3'd0, 3'h7}));

    // R9 halt and wake together in run: halt wins
    set_cfg(5'b00000); halt_i = 1'b1; wake_i = 1'b1; tick();
    halt_i = 1'b0; wake_i = 1'b0;
    check("R9", "halt beats wake", 8'(mode_o), 8'd1);
    // R8 halt on the wake edge: back to run, no clear
    halt_i = 1'b1; wake_i = 1'b1; tick(); halt_i = 1'b0; wake_i = 1'b0;
    check("R8", "halt on wake edge", 8'({mode_o, wdt_clr_o}), 8'd0);

    // R10 entry beats software clear
    pdf_clr_i = 1'b1; tick(); pdf_clr_i = 1'b0;
    check("R10", "pdf clr", 8'(pdf_o), 8'd0);
    set_cfg(5'b10000); halt_i = 1'b1; pdf_clr_i = 1'b1; tick();
    halt_i = 1'b0; pdf_clr_i = 1'b0;
    check("R10", "entry wins pdf", 8'(pdf_o), 8'd1);
    wake_i = 1'b1; tick(); wake_i = 1'b0;

    // R11 entry beats time-out
    wdt_timeout_i = 1'b1; halt_i = 1'b1; set_cfg(5'b01001); tick();
    halt_i = 1'b0; wdt_timeout_i = 1'b0;
    check("R11", "entry wins to", 8'(to_o), 8'd0);
    check("R3", "sleep1 mode", 8'(mode_o), 8'd2);

    // R1 reset while asleep
    wdt_timeout_i = 1'b1; tick(); wdt_timeout_i = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1", "reset asleep mode", 8'(mode_o), 8'd0);
    check("R1", "reset asleep enables", 8'(ens()), 8'h7);
    check("R1", "reset asleep flags", 8'({pdf_o, to_o, wdt_clr_o}), 8'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule